// File: doc/BRIEF.md
# Decimal Accumulator Processor

This block is a small multi-cycle processor built around one accumulator and a 100-word data/program store addressed in decimal (00 to 99). Each instruction is carried out as an explicit chain of single register transfers. The program counter, instruction register, memory address register, memory data register, accumulator and I/O register are all real registers. Every access to the store goes through the address register and the data register, and each transfer takes one named microstep. The decimal instruction format keeps programs readable as three-digit numbers. Indirect load and store add a pointer-read phase before the data access.

The store is filled through a preload port while reset is held. Releasing reset starts execution at address 00. Input values arrive over a valid/ready handshake, and the processor stalls until a value is offered. Output values leave on a data port qualified by a one-cycle strobe. A halted flag reports that the program has stopped.

Top module: `decimal_acc_cpu`

## Requirements
- R1: While reset is high, the block holds halted, out_valid and in_ready low and clears PC, IR, MAR, MDR, accumulator and I/O register. The store is not cleared. Preload writes with an address of 00..99 are accepted. After release, fetching starts at address 00 with the accumulator equal to 0.
- R2: Every instruction begins with three one-cycle fetch steps: PC to MAR, store[MAR] to MDR, MDR to IR. Words are decimal: hundreds digit 1=ADD, 2=SUB, 3=STORE, 4=indirect LOAD, 5=LOAD, 6=BRANCH, 7=BRANCH if accumulator is zero, 8=BRANCH if accumulator is at least 0. 901=IN and 902=OUT. 910..999 is indirect STORE, using the low two digits. The low two digits are the address field.
- R3: LOAD, ADD and SUB take 7 cycles: fetch, IR address to MAR, store to MDR, accumulator update, PC increment.
- R4: STORE takes 7 cycles: fetch, IR address to MAR, accumulator to MDR, MDR written to store[MAR], PC increment.
- R5: IN raises in_ready in its 4th cycle and holds it until in_valid is high at a clock edge. It then takes in_data (clamped to −999..999) into the I/O register, copies it to the accumulator, and increments PC.
- R6: OUT copies the accumulator to the I/O register and raises out_valid for exactly one cycle, the 5th of the instruction, with out_data equal to the accumulator. The 6th cycle increments PC.
- R7: Branches take 4 cycles. The 4th cycle loads PC with the address field when the condition holds (always for code 6) and increments PC otherwise.
- R8: HALT (000..099, 900) and every undefined word (903..909, values outside 0..999) stop the block after the three fetch cycles. halted is high from the 4th cycle on, PC is not incremented, and no further strobes occur.
- R9: Indirect LOAD/STORE take 9 cycles. The word at the address field is read through MAR/MDR. The magnitude of that word modulo 100 is placed in MAR as the effective address, and the data access then proceeds as in R3/R4.
- R10: PC increments from 99 wrap to 00.
- R11: The accumulator stays within −999..999. ADD and SUB results, and loaded store words, are clamped to that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | 7 | Preload address, 0..99 |
| pl_data | input | 11 | Preload word, signed |
| in_data | input | 11 | Input value, signed |
| in_valid | input | 1 | Input value offered |
| in_ready | output | 1 | Block waiting in an IN step |
| out_data | output | 11 | I/O register, signed |
| out_valid | output | 1 | One-cycle output strobe |
| halted | output | 1 | Program stopped |

## Verification
The bench runs a behavioural per-cycle model beside the block and checks the strobe, ready and halted timing on every clock. A wrong fetch or execute step count therefore shows up as a mismatch at once. Directed programs target the following cases:
- Clamping at both ends. A missing clamp gives 1400 or −1000-class values.
- An IN stalled for several cycles. A block that does not wait takes a stale value.
- A countdown loop with taken and untaken branches, including zero at the "at least 0" test. A wrong condition changes the sequence of outputs.
- Pointer chains through a negative pointer word. Using raw bits instead of the magnitude reads the wrong cell.
- A run from 99 into 00, ending on an undefined code. A PC that does not wrap or a decoder that ignores undefined words runs away instead of halting.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    localparam int WORD_W     = 11;
    localparam int MEM_WORDS  = 100;
    localparam int ADDR_W     = $clog2(MEM_WORDS);
    localparam int VAL_MAX    = 999;
    localparam int DIGIT_BASE = 10;
    localparam int FIELD_MOD  = DIGIT_BASE * DIGIT_BASE;
    localparam int SUB_IN     = 1;
    localparam int SUB_OUT    = 2;
    localparam int SUB_IND_LO = 10;

    typedef logic signed [WORD_W-1:0] word_t;
    typedef logic signed [WORD_W:0]   wide_t;
    typedef logic [ADDR_W-1:0]        addr_t;

    typedef enum logic [3:0] {
        OP_HALT, OP_ADD, OP_SUB, OP_STORE, OP_LOAD, OP_LDI, OP_STI,
        OP_BR, OP_BRZ, OP_BRP, OP_IN, OP_OUT
    } op_e;

    typedef struct packed {
        op_e   op;
        addr_t addr;
    } instr_t;

    typedef enum logic [4:0] {
        ST_FETCH_MAR, ST_FETCH_MDR, ST_FETCH_IR,
        ST_OPND_MAR, ST_PTR_MDR, ST_PTR_MAR, ST_OPND_MDR, ST_ALU,
        ST_ACC_MDR, ST_MEM_WR,
        ST_IN_WAIT, ST_IOR_ACC, ST_ACC_IOR, ST_OUT_STB,
        ST_BRANCH, ST_PC_INC, ST_HALT
    } step_e;

    function automatic word_t clamp_val(wide_t x);
        if (x > wide_t'(VAL_MAX))
            return word_t'(VAL_MAX);
        if (x < -wide_t'(VAL_MAX))
            return -word_t'(VAL_MAX);
        return word_t'(x);
    endfunction

    function automatic instr_t decode_word(word_t w);
        instr_t d;
        int v;
        int hi;
        int lo;
        v      = int'(w);
        d.op   = OP_HALT;
        d.addr = '0;
        if (v >= 0 && v <= VAL_MAX) begin
            hi     = v / FIELD_MOD;
            lo     = v % FIELD_MOD;
            d.addr = addr_t'(lo);
            case (hi)
                1: d.op = OP_ADD;
                2: d.op = OP_SUB;
                3: d.op = OP_STORE;
                4: d.op = OP_LDI;
                5: d.op = OP_LOAD;
                6: d.op = OP_BR;
                7: d.op = OP_BRZ;
                8: d.op = OP_BRP;
                9: begin
                    if (lo == SUB_IN)
                        d.op = OP_IN;
                    else if (lo == SUB_OUT)
                        d.op = OP_OUT;
                    else if (lo >= SUB_IND_LO)
                        d.op = OP_STI;
                end
                default: d.op = OP_HALT;
            endcase
        end
        return d;
    endfunction

    function automatic addr_t ptr_addr(word_t w);
        int v;
        v = int'(w);
        if (v < 0)
            v = -v;
        return addr_t'(v % MEM_WORDS);
    endfunction

    function automatic addr_t next_pc(addr_t p);
        if (p == addr_t'(MEM_WORDS - 1))
            return addr_t'(0);
        return addr_t'(p + 1'b1);
    endfunction

endpackage

// File: rtl/dacc_mem.sv
module dacc_mem
    import dacc_pkg::*;
#(
    parameter int DEPTH = MEM_WORDS
) (
    input  logic  clk,
    input  logic  pl_we,
    input  addr_t pl_addr,
    input  word_t pl_data,
    input  logic  cpu_we,
    input  addr_t cpu_addr,
    input  word_t cpu_wdata,
    output word_t cpu_rdata
);

    word_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (pl_we && (int'(pl_addr) < DEPTH))
            cells[pl_addr] <= pl_data;
        else if (cpu_we && (int'(cpu_addr) < DEPTH))
            cells[cpu_addr] <= cpu_wdata;
    end

    assign cpu_rdata = (int'(cpu_addr) < DEPTH) ? cells[cpu_addr] : '0;

    // R4: the core only ever writes inside the 100-word range
    a_r4_write_in_range: assert property (@(posedge clk)
        cpu_we |-> (int'(cpu_addr) < DEPTH));

endmodule

// File: rtl/dacc_alu.sv
module dacc_alu
    import dacc_pkg::*;
(
    input  op_e   op,
    input  word_t acc,
    input  word_t opnd,
    output word_t result,
    output logic  take_branch
);

    wide_t acc_w;
    wide_t opnd_w;

    assign acc_w  = wide_t'(acc);
    assign opnd_w = wide_t'(opnd);

    always_comb begin
        case (op)
            OP_ADD:  result = clamp_val(acc_w + opnd_w);
            OP_SUB:  result = clamp_val(acc_w - opnd_w);
            default: result = clamp_val(opnd_w);
        endcase
    end

    always_comb begin
        case (op)
            OP_BR:   take_branch = 1'b1;
            OP_BRZ:  take_branch = (acc == '0);
            OP_BRP:  take_branch = !acc[WORD_W-1];
            default: take_branch = 1'b0;
        endcase
    end

endmodule

// File: rtl/dacc_seq.sv
module dacc_seq
    import dacc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t mem_rdata,
    output logic  mem_we,
    output addr_t mem_addr,
    output word_t mem_wdata,
    output op_e   alu_op,
    output word_t alu_acc,
    output word_t alu_opnd,
    input  word_t alu_res,
    input  logic  alu_take,
    input  word_t in_data,
    input  logic  in_valid,
    output logic  in_ready,
    output word_t out_data,
    output logic  out_valid,
    output logic  halted
);

    step_e  state;
    addr_t  pc;
    addr_t  mar;
    word_t  ir;
    word_t  mdr;
    word_t  acc;
    word_t  ior;
    instr_t ir_dec;
    instr_t mdr_dec;

    always_comb begin
        ir_dec  = decode_word(ir);
        mdr_dec = decode_word(mdr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH_MAR;
            pc    <= '0;
            mar   <= '0;
            ir    <= '0;
            mdr   <= '0;
            acc   <= '0;
            ior   <= '0;
        end else begin
            case (state)
                ST_FETCH_MAR: begin
                    mar   <= pc;
                    state <= ST_FETCH_MDR;
                end
                ST_FETCH_MDR: begin
                    mdr   <= mem_rdata;
                    state <= ST_FETCH_IR;
                end
                ST_FETCH_IR: begin
                    ir <= mdr;
                    case (mdr_dec.op)
                        OP_ADD, OP_SUB, OP_LOAD, OP_STORE, OP_LDI, OP_STI:
                            state <= ST_OPND_MAR;
                        OP_IN:                 state <= ST_IN_WAIT;
                        OP_OUT:                state <= ST_ACC_IOR;
                        OP_BR, OP_BRZ, OP_BRP: state <= ST_BRANCH;
                        default:               state <= ST_HALT;
                    endcase
                end
                ST_OPND_MAR: begin
                    mar <= ir_dec.addr;
                    if (ir_dec.op == OP_LDI || ir_dec.op == OP_STI)
                        state <= ST_PTR_MDR;
                    else if (ir_dec.op == OP_STORE)
                        state <= ST_ACC_MDR;
                    else
                        state <= ST_OPND_MDR;
                end
                ST_PTR_MDR: begin
                    mdr   <= mem_rdata;
                    state <= ST_PTR_MAR;
                end
                ST_PTR_MAR: begin
                    mar   <= ptr_addr(mdr);
                    state <= (ir_dec.op == OP_STI) ? ST_ACC_MDR : ST_OPND_MDR;
                end
                ST_OPND_MDR: begin
                    mdr   <= mem_rdata;
                    state <= ST_ALU;
                end
                ST_ALU: begin
                    acc   <= alu_res;
                    state <= ST_PC_INC;
                end
                ST_ACC_MDR: begin
                    mdr   <= acc;
                    state <= ST_MEM_WR;
                end
                ST_MEM_WR: state <= ST_PC_INC;
                ST_IN_WAIT: begin
                    if (in_valid) begin
                        ior   <= clamp_val(wide_t'(in_data));
                        state <= ST_IOR_ACC;
                    end
                end
                ST_IOR_ACC: begin
                    acc   <= ior;
                    state <= ST_PC_INC;
                end
                ST_ACC_IOR: begin
                    ior   <= acc;
                    state <= ST_OUT_STB;
                end
                ST_OUT_STB: state <= ST_PC_INC;
                ST_BRANCH: begin
                    pc    <= alu_take ? ir_dec.addr : next_pc(pc);
                    state <= ST_FETCH_MAR;
                end
                ST_PC_INC: begin
                    pc    <= next_pc(pc);
                    state <= ST_FETCH_MAR;
                end
                ST_HALT: state <= ST_HALT;
                default: state <= ST_FETCH_MAR;
            endcase
        end
    end

    assign mem_we    = (state == ST_MEM_WR);
    assign mem_addr  = mar;
    assign mem_wdata = mdr;
    assign alu_op    = ir_dec.op;
    assign alu_acc   = acc;
    assign alu_opnd  = mdr;
    assign in_ready  = (state == ST_IN_WAIT);
    assign out_valid = (state == ST_OUT_STB);
    assign out_data  = ior;
    assign halted    = (state == ST_HALT);

    a_r10_pc_bound: assert property (@(posedge clk) disable iff (rst)
        int'(pc) < MEM_WORDS);

    a_r2_mar_bound: assert property (@(posedge clk) disable iff (rst)
        int'(mar) < MEM_WORDS);

    a_r11_acc_range: assert property (@(posedge clk) disable iff (rst)
        (acc <= word_t'(VAL_MAX)) && (acc >= -word_t'(VAL_MAX)));

    a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(pc) && !out_valid);

    a_r5_in_stall: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> in_ready && $stable(acc));

    a_r7_branch_target: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BRANCH && alu_take) |=> (pc == $past(ir_dec.addr)));

endmodule

// File: rtl/decimal_acc_cpu.sv
module decimal_acc_cpu
    import dacc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pl_we,
    input  logic [ADDR_W-1:0]        pl_addr,
    input  logic signed [WORD_W-1:0] pl_data,
    input  logic signed [WORD_W-1:0] in_data,
    input  logic                     in_valid,
    output logic                     in_ready,
    output logic signed [WORD_W-1:0] out_data,
    output logic                     out_valid,
    output logic                     halted
);

    word_t mem_rdata;
    logic  mem_we;
    addr_t mem_addr;
    word_t mem_wdata;
    op_e   alu_op;
    word_t alu_acc;
    word_t alu_opnd;
    word_t alu_res;
    logic  alu_take;

    dacc_mem #(.DEPTH(MEM_WORDS)) u_mem (
        .clk       (clk),
        .pl_we     (pl_we),
        .pl_addr   (pl_addr),
        .pl_data   (pl_data),
        .cpu_we    (mem_we),
        .cpu_addr  (mem_addr),
        .cpu_wdata (mem_wdata),
        .cpu_rdata (mem_rdata)
    );

    dacc_alu u_alu (
        .op          (alu_op),
        .acc         (alu_acc),
        .opnd        (alu_opnd),
        .result      (alu_res),
        .take_branch (alu_take)
    );

    dacc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .alu_op    (alu_op),
        .alu_acc   (alu_acc),
        .alu_opnd  (alu_opnd),
        .alu_res   (alu_res),
        .alu_take  (alu_take),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .halted    (halted)
    );

endmodule

// File: tb/sim_decimal_acc_cpu.sv
`timescale 1ns/1ps
module sim_decimal_acc_cpu;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic               rst = 1'b1;
    logic               pl_we = 1'b0;
    logic [6:0]         pl_addr = '0;
    logic signed [10:0] pl_data = '0;
    logic signed [10:0] in_data = '0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic signed [10:0] out_data;
    logic               out_valid;
    logic               halted;

    decimal_acc_cpu u0 (
        .clk(clk), .rst(rst), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .halted(halted)
    );

    localparam int K_HALT = 0, K_ADD = 1, K_SUB = 2, K_STO = 3, K_LDI = 4, K_LOD = 5;
    localparam int K_BR = 6, K_BRZ = 7, K_BRP = 8, K_IN = 9, K_OUT = 10, K_STI = 11;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    mem_m [100];
    int    pc_m, acc_m, ior_m, ph, op_m, a_m, len_m;
    bit    halted_m;
    bit    consumed = 1'b0;
    int    in_q [$];
    int    got [$];
    int    exp_q [$];
    int    gap = 0;
    int    gap_cnt = 0;
    string tag = "R1";

    function automatic int sat(int x);
        if (x > 999) return 999;
        if (x < -999) return -999;
        return x;
    endfunction

    function automatic int ptr(int v);
        return ((v < 0) ? -v : v) % 100;
    endfunction

    function automatic int dec_op(int w);
        int hi, lo;
        if (w < 0 || w > 999) return K_HALT;
        hi = w / 100;
        lo = w % 100;
        case (hi)
            1: return K_ADD;
            2: return K_SUB;
            3: return K_STO;
            4: return K_LDI;
            5: return K_LOD;
            6: return K_BR;
            7: return K_BRZ;
            8: return K_BRP;
            9: begin
                if (lo == 1) return K_IN;
                if (lo == 2) return K_OUT;
                if (lo >= 10) return K_STI;
                return K_HALT;
            end
            default: return K_HALT;
        endcase
    endfunction

    function automatic int dec_len(int op);
        case (op)
            K_LDI, K_STI:               return 9;
            K_IN, K_OUT:                return 6;
            K_BR, K_BRZ, K_BRP:         return 4;
            default:                    return 7;
        endcase
    endfunction

    function automatic void exec_m();
        bit taken;
        taken = 1'b0;
        case (op_m)
            K_LOD: acc_m = sat(mem_m[a_m]);
            K_ADD: acc_m = sat(acc_m + mem_m[a_m]);
            K_SUB: acc_m = sat(acc_m - mem_m[a_m]);
            K_STO: mem_m[a_m] = acc_m;
            K_LDI: acc_m = sat(mem_m[ptr(mem_m[a_m])]);
            K_STI: mem_m[ptr(mem_m[a_m])] = acc_m;
            K_IN:  acc_m = ior_m;
            K_OUT: ior_m = acc_m;
            K_BR:  taken = 1'b1;
            K_BRZ: taken = (acc_m == 0);
            K_BRP: taken = (acc_m >= 0);
            default: ;
        endcase
        pc_m = taken ? a_m : (pc_m + 1) % 100;
    endfunction

    task automatic chk(string req, string what, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // reference model: advances one phase per clock
    always @(posedge clk) begin
        if (rst) begin
            pc_m = 0; acc_m = 0; ior_m = 0; ph = 1; halted_m = 1'b0;
            op_m = K_HALT; a_m = 0; len_m = 7;
        end else if (!halted_m) begin
            if (ph < 3) begin
                ph++;
            end else if (ph == 3) begin
                op_m  = dec_op(mem_m[pc_m]);
                a_m   = (mem_m[pc_m] >= 0) ? mem_m[pc_m] % 100 : 0;
                len_m = dec_len(op_m);
                if (op_m == K_HALT) halted_m = 1'b1;
                ph = 4;
            end else if (op_m == K_IN && ph == 4) begin
                if (in_valid) begin
                    ior_m    = sat(int'(in_data));
                    consumed = 1'b1;
                    ph       = 5;
                end
            end else if (ph == len_m) begin
                exec_m();
                ph = 1;
            end else begin
                ph++;
            end
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #1;
        if (rst) begin
            chk("R1", "halted in reset", int'(halted), 0);
            chk("R1", "out_valid in reset", int'(out_valid), 0);
            chk("R1", "in_ready in reset", int'(in_ready), 0);
        end else begin
            chk("R5", "in_ready", int'(in_ready),
                int'(!halted_m && ph == 4 && op_m == K_IN));
            chk("R2", "out_valid timing", int'(out_valid),
                int'(!halted_m && ph == 5 && op_m == K_OUT));
            chk("R8", "halted", int'(halted), int'(halted_m));
            if (out_valid) begin
                got.push_back(int'(out_data));
                chk("R6", "out_data", int'(out_data), acc_m);
            end
        end
    end

    // input source with programmable gap before each value
    always @(negedge clk) begin
        if (consumed) begin
            consumed = 1'b0;
            void'(in_q.pop_front());
            gap_cnt = gap;
        end
        if (gap_cnt > 0) gap_cnt--;
        in_valid = (in_q.size() > 0) && (gap_cnt == 0);
        in_data  = (in_q.size() > 0) ? 11'(in_q[0]) : '0;
    end

    task automatic put(int a, int v);
        @(negedge clk);
        pl_we   = 1'b1;
        pl_addr = 7'(a);
        pl_data = 11'(v);
        mem_m[a] = v;
    endtask

    task automatic start_test(string t, int g);
        @(negedge clk);
        rst = 1'b1;
        tag = t;
        in_q.delete();
        got.delete();
        exp_q.delete();
        gap = g;
        gap_cnt = g;
        for (int a = 0; a < 100; a++) put(a, 0);
    endtask

    task automatic run_prog();
        @(negedge clk);
        pl_we = 1'b0;
        rst   = 1'b0;
        for (int i = 0; i < 5000 && !halted_m; i++) @(negedge clk);
        chk(tag, "halt reached", int'(halted_m), 1);
        repeat (20) @(negedge clk);
        chk(tag, "output count", got.size(), exp_q.size());
        for (int i = 0; i < exp_q.size(); i++)
            if (i < got.size()) chk(tag, $sformatf("output %0d", i), got[i], exp_q[i]);
    endtask

    initial begin
        #(5.0 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // T1 (R3/R4): load, add, sub, store, reload, output
        start_test("R3/R4", 0);
        put(0, 550); put(1, 151); put(2, 252); put(3, 360);
        put(4, 560); put(5, 902); put(6, 0);
        put(50, 25); put(51, 100); put(52, 30);
        exp_q.push_back(95);
        run_prog();

        // T2 (R11): clamp high, clamp low, clamp of a loaded word
        start_test("R11", 0);
        put(0, 550); put(1, 151); put(2, 902); put(3, 252); put(4, 252);
        put(5, 902); put(6, 553); put(7, 902); put(8, 0);
        put(50, 900); put(51, 500); put(52, 999); put(53, 1023);
        exp_q.push_back(999); exp_q.push_back(-999); exp_q.push_back(999);
        run_prog();

        // T3 (R5): stalled inputs, out-of-range input clamped
        start_test("R5", 6);
        put(0, 901); put(1, 902); put(2, 901); put(3, 150); put(4, 902); put(5, 0);
        put(50, 7);
        in_q.push_back(12); in_q.push_back(-1000);
        exp_q.push_back(12); exp_q.push_back(-992);
        run_prog();

        // T4 (R7): countdown loop, zero and sign conditions
        start_test("R7", 0);
        put(0, 550); put(1, 902); put(2, 251); put(3, 705); put(4, 601);
        put(5, 810); put(6, 0); put(10, 252); put(11, 813); put(12, 902); put(13, 0);
        put(50, 3); put(51, 1); put(52, 5);
        exp_q.push_back(3); exp_q.push_back(2); exp_q.push_back(1); exp_q.push_back(-5);
        run_prog();

        // T5 (R9): indirect load, indirect store through negative pointer
        start_test("R9", 0);
        put(0, 440); put(1, 902); put(2, 941); put(3, 538); put(4, 151);
        put(5, 902); put(6, 0);
        put(40, 145); put(45, 77); put(41, -238); put(51, 1);
        exp_q.push_back(77); exp_q.push_back(78);
        run_prog();

        // T6 (R10): run across 99 into 00, then undefined word 905 halts (R8)
        start_test("R10", 0);
        put(0, 710); put(1, 905); put(10, 550); put(11, 697);
        put(97, 902); put(98, 151); put(99, 902);
        put(50, 11); put(51, 1);
        exp_q.push_back(11); exp_q.push_back(12);
        run_prog();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule